// File: doc/BRIEF.md
# Serial Converter Capture into a Bit-Reversed Frame Buffer

This block runs a 16-bit serial successive-approximation converter at a fixed sample rate of 20 kHz by default. For each conversion it pulls an active-low chip-select line low and generates the converter's serial clock. It discards the clock periods in which the converter is still settling. It then shifts the result in on one data line, most significant bit first.

Each finished sample is written once into an external frame buffer. The address is the bit-reversed form of the sample's arrival index within the frame. When the frame is full, it is already in the order that a radix-2 decimation-in-time FFT expects, so no separate sorting pass is needed.

After the last index of a frame is written, the block pulses `frame_done` and stops converting. A new `start` pulse begins the next frame at index zero.

Top module: `adc_frame_capture`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, and `wr_en` and `frame_done` are 0. No conversion starts until `start` is seen.
- R2: A `start` seen while idle begins a frame. `adc_cs_n` first falls SAMPLE_DIV = CLK_HZ/SAMPLE_HZ clock cycles after the edge that sampled `start`. Each later conversion of the frame begins exactly SAMPLE_DIV cycles after the previous one.
- R3: `adc_sclk` is 0 whenever `adc_cs_n` is 1. It idles low, and during a conversion it toggles every SCLK_HALF clock cycles. Its first toggle, a rise, comes SCLK_HALF cycles after `adc_cs_n` falls.
- R4: The first 3 serial-clock rises of a conversion are ignored; they cover the converter's 2.5-period lead. Bits are sampled on rises 4 to 19, most significant bit first, giving the 16-bit sample.
- R5: `adc_cs_n` returns high 38*SCLK_HALF cycles after it fell, which is one half-period after rise 19. At that edge `adc_sclk` returns low. `adc_cs_n` then stays high until the next sample tick.
- R6: Each conversion produces exactly one write. The write is a single-cycle `wr_en` pulse one clock after `adc_cs_n` rises, with the sample on `wr_data`.
- R7: The sample with arrival index n, counted from 0 at frame start, is written at the address whose bit i equals bit IDX_W-1-i of n. For example, with IDX_W=4, n=1 goes to address 8.
- R8: One cycle after the write of index 2^IDX_W-1, `frame_done` is 1 for exactly one cycle. No further conversion starts until a new `start`.
- R9: `start` asserted while a frame is in progress has no effect on conversion timing or on index order.
- R10: A `start` after `frame_done` begins a new frame whose first sample is written at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| adc_dout | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Active-low conversion/enable strobe |
| wr_en | output | 1 | Frame buffer write enable, one cycle |
| wr_addr | output | IDX_W | Bit-reversed write address |
| wr_data | output | DATA_W | Captured sample |
| frame_done | output | 1 | One-cycle pulse after the last write of a frame |

## Verification
The in-line assertions check these rules on every cycle:
- the serial clock is low whenever the strobe is high;
- a conversion begins only on a sample tick, and never while one is still running;
- a write is a single cycle, and the done pulse follows a write while capture is halted;
- each write address reverses the index that was current one cycle earlier.

Other behaviour needs the bench's scenarios and its converter model. This covers the exact sample spacing, the half-period timing, skipping the three lead rises (the model drives ones there), and the bit order of the captured word. It also covers the full permutation of addresses over a frame, `start` being ignored in mid-frame, and a restart from index zero after the frame ends.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  // serial clock rises spent on the converter's lead before the MSB
  localparam int LEAD_RISES = 3;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_CONV = 2'd1,
    SER_TAIL = 2'd2
  } ser_state_t;
endpackage

// File: rtl/adcf_tick.sv
module adcf_tick #(
  parameter int DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic tick_o,
  output logic armed_o,
  output logic accept_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          wrap_w;

  assign wrap_w   = (cnt_q == CW'(DIV - 1));
  assign accept_o = start_i && !armed_q;
  assign tick_o   = armed_q && wrap_w;
  assign armed_o  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept_o) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (last_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q <= wrap_w ? '0 : cnt_q + 1'b1;
    end
  end

  // R9: a start during a running frame leaves it running
  p_start_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && start_i && !last_i |=> armed_q);
  // R2: arming only follows a start request
  p_arm_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(start_i));
endmodule

// File: rtl/adcf_serial.sv
module adcf_serial
  import adcf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HALF   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dout_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int RISES = LEAD_RISES + DATA_W;
  localparam int RW    = $clog2(RISES + 1);

  ser_state_t        state_q;
  logic [HW-1:0]     hcnt_q;
  logic [RW-1:0]     rcnt_q;
  logic              sclk_q, cs_n_q, done_q;
  logic [DATA_W-1:0] shreg_q;

  // named internal events
  logic half_end_w, rise_w, cap_w, last_rise_w;
  assign half_end_w  = (hcnt_q == HW'(HALF - 1));
  assign rise_w      = (state_q == SER_CONV) && half_end_w && !sclk_q;
  assign cap_w       = rise_w && (rcnt_q >= RW'(LEAD_RISES));
  assign last_rise_w = rise_w && (rcnt_q == RW'(RISES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      hcnt_q  <= '0;
      rcnt_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      shreg_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SER_IDLE: if (tick_i) begin
          state_q <= SER_CONV;
          cs_n_q  <= 1'b0;
          sclk_q  <= 1'b0;
          hcnt_q  <= '0;
          rcnt_q  <= '0;
        end
        SER_CONV: if (half_end_w) begin
          hcnt_q <= '0;
          sclk_q <= ~sclk_q;
          if (rise_w) rcnt_q <= rcnt_q + 1'b1;
          if (cap_w) shreg_q <= {shreg_q[DATA_W-2:0], dout_i};
          if (last_rise_w) state_q <= SER_TAIL;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
        SER_TAIL: if (half_end_w) begin
          hcnt_q  <= '0;
          sclk_q  <= 1'b0;
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= SER_IDLE;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
        default: state_q <= SER_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;
  assign done_o = done_q;
  assign word_o = shreg_q;

  p_sclk_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q);
  p_conv_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> $past(tick_i));
  p_tick_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |-> (state_q == SER_IDLE) && cs_n_q);
  p_done_ends_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q && $past(!cs_n_q));
endmodule

// File: rtl/adcf_index.sv
module adcf_index #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_done_i,
  input  logic [DATA_W-1:0] cap_word_i,
  output logic              last_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              frame_done_o
);
  function automatic logic [IDX_W-1:0] rev_bits(input logic [IDX_W-1:0] v);
    logic [IDX_W-1:0] r;
    for (int i = 0; i < IDX_W; i++) r[i] = v[IDX_W-1-i];
    return r;
  endfunction

  logic [IDX_W-1:0] idx_q;
  logic             wr_last_q;

  assign last_o = cap_done_i && (idx_q == {IDX_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      wr_last_q    <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      wr_en_o      <= cap_done_i;
      wr_last_q    <= last_o;
      frame_done_o <= wr_en_o && wr_last_q;
      if (clear_i) idx_q <= '0;
      else if (cap_done_i) idx_q <= idx_q + 1'b1;
      if (cap_done_i) begin
        wr_addr_o <= rev_bits(idx_q);
        wr_data_o <= cap_word_i;
      end
    end
  end

  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  p_addr_reversed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> rev_bits(wr_addr_o) == $past(idx_q));
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $past(wr_en_o));
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SAMPLE_HZ = 20_000,
  parameter int SCLK_HALF = 8,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_dout,
  output logic              adc_sclk,
  output logic              adc_cs_n,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done
);
  localparam int SAMPLE_DIV = CLK_HZ / SAMPLE_HZ;

  logic              tick_w, armed_w, accept_w, last_w, cap_done_w;
  logic [DATA_W-1:0] cap_word_w;

  adcf_tick #(.DIV(SAMPLE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .start_i(start), .last_i(last_w),
    .tick_o(tick_w), .armed_o(armed_w), .accept_o(accept_w)
  );

  adcf_serial #(.DATA_W(DATA_W), .HALF(SCLK_HALF)) u_serial (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .dout_i(adc_dout),
    .sclk_o(adc_sclk), .cs_n_o(adc_cs_n), .done_o(cap_done_w),
    .word_o(cap_word_w)
  );

  adcf_index #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_index (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .cap_done_i(cap_done_w),
    .cap_word_i(cap_word_w), .last_o(last_w), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .frame_done_o(frame_done)
  );

  // R8: capture is halted when the done pulse appears
  p_halt_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !armed_w);
  // R5: a conversion must fit in one sample period
  initial begin
    p_fits_period_r5: assert (SAMPLE_DIV > (2 * adcf_pkg::LEAD_RISES + 2 * DATA_W + 4) * SCLK_HALF);
  end
endmodule

// File: tb/adc_frame_capture_bench.sv
module adc_frame_capture_bench;
  localparam int DIV  = 100;
  localparam int HALF = 2;
  localparam int IW   = 4;
  localparam int NS   = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_dout = 1'b1;
  logic adc_sclk, adc_cs_n, wr_en, frame_done;
  logic [IW-1:0] wr_addr;
  logic [15:0]   wr_data;

  adc_frame_capture #(.CLK_HZ(50_000_000), .SAMPLE_HZ(500_000), .SCLK_HALF(HALF),
                      .DATA_W(16), .IDX_W(IW)) u_adc_frame_capture (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_dout(adc_dout),
    .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] word_of(input int f, input int n);
    int v;
    v = (n * 40503 + f * 12345 + 777) ^ (n << 11);
    return v[15:0];
  endfunction

  function automatic int rev_of(input int v);
    int r = 0;
    for (int i = 0; i < IW; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  // reference model state
  bit running = 0, mon_on = 0;
  int ref_cyc, evt_cyc, fall_cyc, rise_cyc, last_wr_cyc, last_wr_idx;
  int idx_b, fcnt, frame_no = 0, writes = 0, dones = 0, cs_falls = 0;
  int addr_of_idx1, first_addr_f2 = -1;
  logic [15:0] cur_word;
  logic [NS-1:0] seen;
  logic [15:0] q_word[$];
  int q_idx[$];
  logic p_cs = 1'b1, p_sclk = 1'b0, p_wr = 1'b0;

  always @(negedge clk) if (mon_on) begin
    chk(!(adc_cs_n && adc_sclk), "R3 sclk low while cs high", adc_sclk, 0);
    if (p_cs && !adc_cs_n) begin
      cs_falls++;
      chk(running, "R8/R1 conversion only in a frame", 0, 1);
      chk(cyc - ref_cyc == DIV, "R2 sample spacing", cyc - ref_cyc, DIV);
      ref_cyc = cyc; fall_cyc = cyc; evt_cyc = cyc; fcnt = 0;
      cur_word = word_of(frame_no, idx_b);
      q_word.push_back(cur_word); q_idx.push_back(idx_b);
      idx_b++;
    end
    if (!p_cs && adc_cs_n) begin
      chk(cyc - fall_cyc == 38 * HALF, "R5 strobe low length", cyc - fall_cyc, 38 * HALF);
      rise_cyc = cyc;
    end
    if (adc_sclk != p_sclk) begin
      chk(cyc - evt_cyc == HALF, "R3 half period", cyc - evt_cyc, HALF);
      evt_cyc = cyc;
      if (!adc_sclk) begin
        fcnt++;
        // converter model: ones during lead, MSB launched on fall 3
        adc_dout = (fcnt >= 3 && fcnt <= 18) ? cur_word[15 - (fcnt - 3)] : 1'b1;
      end
    end
    if (wr_en) begin
      chk(!p_wr, "R6 single-cycle write", 1, 0);
      chk(cyc == rise_cyc + 1, "R6 write timing", cyc, rise_cyc + 1);
      if (q_idx.size() == 0) chk(0, "R6 unexpected write", 1, 0);
      else begin
        int n;
        logic [15:0] w;
        n = q_idx.pop_front(); w = q_word.pop_front();
        chk(int'(wr_addr) == rev_of(n), "R7 reversed address", wr_addr, rev_of(n));
        chk(wr_data == w, "R4 captured word", wr_data, w);
        seen[wr_addr] = 1'b1;
        if (n == 1 && frame_no == 1) addr_of_idx1 = wr_addr;
        if (n == 0 && frame_no == 2) first_addr_f2 = wr_addr;
        last_wr_idx = n;
      end
      writes++; last_wr_cyc = cyc;
    end
    if (frame_done) begin
      chk(cyc == last_wr_cyc + 1 && last_wr_idx == NS - 1, "R8 done after last write",
          last_wr_idx, NS - 1);
      dones++; running = 0;
    end
    p_cs = adc_cs_n; p_sclk = adc_sclk; p_wr = wr_en;
  end

  task automatic pulse_start;
    @(negedge clk);
    if (!running) begin
      running = 1; idx_b = 0; frame_no++; ref_cyc = cyc + 1; seen = '0;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 20000 && dones < n; k++) @(negedge clk);
    chk(dones >= n, "R8 frame completes", dones, n);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 reset strobe", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 reset sclk", adc_sclk, 0);
    chk(wr_en == 1'b0, "R1 reset wr_en", wr_en, 0);
    chk(frame_done == 1'b0, "R1 reset done", frame_done, 0);
    mon_on = 1;
    repeat (300) @(negedge clk);
    chk(cs_falls == 0, "R1 idle without start", cs_falls, 0);

    pulse_start();
    repeat (5 * DIV + 30) @(negedge clk);
    pulse_start();                      // R9: mid-frame start, must be ignored
    wait_done(1);
    chk(writes == NS, "R6 one write per sample", writes, NS);
    chk(&seen, "R7 all addresses written", int'(seen), NS);
    chk(addr_of_idx1 == NS / 2, "R7 index 1 to top bit", addr_of_idx1, NS / 2);
    repeat (3 * DIV) @(negedge clk);
    chk(cs_falls == NS, "R8 halted after frame", cs_falls, NS);
    chk(dones == 1, "R8 single done pulse", dones, 1);

    pulse_start();                      // R10: restart
    wait_done(2);
    chk(writes == 2 * NS, "R10 second frame writes", writes, 2 * NS);
    chk(first_addr_f2 == 0, "R10 restart at index 0", first_addr_f2, 0);
    chk(q_idx.size() == 0, "R6 no missing writes", q_idx.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", dones, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule